// File: doc/BRIEF.md
# Pulse-Qualified Calibration Sequencer

This block decides when a converter's self-calibration runs. A calibration can start in two ways. The first is automatic: once reset is released, a wait counter runs and a calibration begins when it expires. The second is on request: the request line must first sit low for a minimum number of cycles and then sit high for the same minimum. A single edge does not start anything, and short glitches in either phase are rejected.

While a calibration is running, a busy flag is raised. The calibration itself is represented by a fixed countdown. A configuration input can also gate the enable of the forwarded data clock for as long as the busy flag is up. A power-down input cancels whatever is in progress, whether that is the start-up wait or a running calibration, and leaves the block idle.

Top module: `pulse_cal_seq`

## Requirements
- R1: While `rstN` is low, `calBusy` is 0 and `dclkEn` is 1.
- R2: With `dlySelLong`=0, `calBusy` rises on exactly the 2^SHORT_LOG2-th rising clock edge after `rstN` is released. The default is 2^8.
- R3: With `dlySelLong`=1 and `extCtrlEn`=0, `calBusy` rises on exactly the 2^LONG_LOG2-th rising clock edge after `rstN` is released. The default is 2^16.
- R4: When `extCtrlEn`=1, the start-up wait uses the short value whatever the level of `dlySelLong`.
- R5: Once `calBusy` rises, it stays high for exactly CAL_CYCLES clock cycles (default 1024) and then falls, unless power-down intervenes.
- R6: In idle, a calibration starts when `calReq` has been sampled low on at least QUAL_CYCLES consecutive edges (default 80) and then sampled high on QUAL_CYCLES consecutive edges. `calBusy` rises on the edge that samples the QUAL_CYCLES-th high.
- R7: A low phase shorter than QUAL_CYCLES does not arm the qualifier, so a following high phase of any length starts nothing.
- R8: If an armed high phase ends before QUAL_CYCLES, the low phase must then be counted again in full before a high phase can qualify.
- R9: Activity on `calReq` during a calibration is ignored. This includes low time: it does not count toward the qualifier, and it neither extends nor restarts the calibration.
- R10: When `powerDown` is sampled high, `calBusy` is 0 from that edge onward. The block then stays idle with its qualifier cleared until `powerDown` falls, and no start-up calibration is resumed afterward.
- R11: `dclkEn` is 0 exactly while `calBusy` is 1 and `holdClkCfg` is 1; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| calReq | input | 1 | Calibration request line, qualified by phase length |
| powerDown | input | 1 | Aborts any activity and holds the block idle |
| dlySelLong | input | 1 | Selects the long start-up wait |
| extCtrlEn | input | 1 | Extended-control mode; forces the short start-up wait |
| holdClkCfg | input | 1 | Gate the data clock enable during calibration |
| calBusy | output | 1 | High while a calibration runs |
| dclkEn | output | 1 | Enable for the forwarded data clock |

## Verification
The bench builds the block with SHORT_LOG2=4, LONG_LOG2=7 and CAL_CYCLES=40, and keeps QUAL_CYCLES at its default of 80. With the short wait at 16 cycles and the long wait at 128, all three start-up variants can be run from reset in a few hundred cycles. The 40-cycle countdown is shorter than a full qualifying pattern, so request low time that lands inside a calibration would be visibly wrong if it were counted. Keeping the real qualifier length means the boundary patterns at 79, 80 and 81 cycles are tested at their true values, in directed form and as randomized phase lengths around that threshold.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_CAL  = 2'd2
  } calState_e;

  typedef struct packed {
    logic qualEn;
    logic dlyInc;
    logic calLoad;
    logic calDec;
  } seqStrobe_t;

endpackage

// File: rtl/calseq_qual.sv
module calseq_qual #(
  parameter int QUAL_CYCLES = 80
) (
  input  logic clk,
  input  logic rstN,
  input  logic qualEn,
  input  logic calReq,
  output logic fire
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] PHASE_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [QW-1:0] PHASE_FULL = QW'(QUAL_CYCLES);

  logic [QW-1:0] lowCnt;
  logic [QW-1:0] highCnt;
  logic          armed;

  assign fire = qualEn & calReq & armed & (highCnt == PHASE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
      armed   <= 1'b0;
    end else if (!qualEn) begin
      lowCnt  <= '0;
      highCnt <= '0;
      armed   <= 1'b0;
    end else if (!calReq) begin
      highCnt <= '0;
      if (lowCnt != PHASE_FULL) lowCnt <= lowCnt + 1'b1;
      armed <= (lowCnt >= PHASE_LAST);
    end else begin
      lowCnt <= '0;
      if (fire) begin
        armed   <= 1'b0;
        highCnt <= '0;
      end else if (armed) begin
        highCnt <= highCnt + 1'b1;
      end
    end
  end

  // R6
  arm_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(!calReq));

  // R7
  arm_needs_full_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> ($past(lowCnt) >= PHASE_LAST));

endmodule

// File: rtl/calseq_timer.sv
module calseq_timer #(
  parameter int SHORT_LOG2 = 8,
  parameter int LONG_LOG2  = 16,
  parameter int CAL_CYCLES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic useLong,
  input  logic dlyInc,
  input  logic calLoad,
  input  logic calDec,
  output logic dlyDone,
  output logic calZero
);
  localparam int DW = LONG_LOG2;
  localparam int CW = (CAL_CYCLES > 2) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [DW-1:0] SHORT_LAST = DW'((64'd1 << SHORT_LOG2) - 64'd1);
  localparam logic [DW-1:0] LONG_LAST  = {DW{1'b1}};
  localparam logic [CW-1:0] CAL_LAST   = CW'(CAL_CYCLES - 1);

  logic [DW-1:0] dlyCnt;
  logic [DW-1:0] dlyLast;
  logic [CW-1:0] calCnt;

  assign dlyLast = useLong ? LONG_LAST : SHORT_LAST;
  assign dlyDone = (dlyCnt >= dlyLast);
  assign calZero = (calCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dlyCnt <= '0;
    else if (dlyInc) dlyCnt <= dlyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        calCnt <= '0;
    else if (calLoad) calCnt <= CAL_LAST;
    else if (calDec)  calCnt <= calCnt - 1'b1;
  end

  // R5
  cal_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    calDec |-> (calCnt != '0));

  // R5
  cal_load_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    calLoad |=> (calCnt == CAL_LAST));

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
  import calseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic       fire,
  input  logic       dlyDone,
  input  logic       calZero,
  output logic       busy,
  output seqStrobe_t stb
);
  calState_e state;
  calState_e stateNxt;

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    stb.qualEn  = (state == ST_IDLE) && !powerDown;
    if (powerDown) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_WAIT: begin
          if (dlyDone) begin
            stateNxt    = ST_CAL;
            stb.calLoad = 1'b1;
          end else begin
            stb.dlyInc = 1'b1;
          end
        end
        ST_IDLE: begin
          if (fire) begin
            stateNxt    = ST_CAL;
            stb.calLoad = 1'b1;
          end
        end
        ST_CAL: begin
          if (calZero) stateNxt   = ST_IDLE;
          else         stb.calDec = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNxt;
  end

  assign busy = (state == ST_CAL);

  // R10
  pd_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !busy);

  // R2
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fire || dlyDone));

  // R5
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(calZero || powerDown));

  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !fire);

  // R3
  wait_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dlyInc |-> !dlyDone);

endmodule

// File: rtl/pulse_cal_seq.sv
module pulse_cal_seq
  import calseq_pkg::*;
#(
  parameter int QUAL_CYCLES = 80,
  parameter int SHORT_LOG2  = 8,
  parameter int LONG_LOG2   = 16,
  parameter int CAL_CYCLES  = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic calReq,
  input  logic powerDown,
  input  logic dlySelLong,
  input  logic extCtrlEn,
  input  logic holdClkCfg,
  output logic calBusy,
  output logic dclkEn
);
  seqStrobe_t stb;
  logic       fire;
  logic       dlyDone;
  logic       calZero;
  logic       useLong;

  assign useLong = dlySelLong & ~extCtrlEn;

  calseq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) uQual (
    .clk    (clk),
    .rstN   (rstN),
    .qualEn (stb.qualEn),
    .calReq (calReq),
    .fire   (fire)
  );

  calseq_timer #(
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2),
    .CAL_CYCLES (CAL_CYCLES)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .useLong (useLong),
    .dlyInc  (stb.dlyInc),
    .calLoad (stb.calLoad),
    .calDec  (stb.calDec),
    .dlyDone (dlyDone),
    .calZero (calZero)
  );

  calseq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .fire      (fire),
    .dlyDone   (dlyDone),
    .calZero   (calZero),
    .busy      (calBusy),
    .stb       (stb)
  );

  assign dclkEn = ~(calBusy & holdClkCfg);

  // R4
  ext_short_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extCtrlEn && stb.dlyInc) |-> !useLong);

endmodule

// File: tb/pulse_cal_seq_test.sv
module pulse_cal_seq_test;
  localparam int QUAL = 80;
  localparam int CALN = 40;
  localparam int SLOG = 4;
  localparam int LLOG = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, calReq, powerDown, dlySelLong, extCtrlEn, holdClkCfg;
  logic calBusy, dclkEn;

  int total = 0;
  int bad   = 0;

  int mMode, mLow, mHigh, mRemain;
  bit mArmed;

  pulse_cal_seq #(
    .QUAL_CYCLES (QUAL),
    .SHORT_LOG2  (SLOG),
    .LONG_LOG2   (LLOG),
    .CAL_CYCLES  (CALN)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .calReq     (calReq),
    .powerDown  (powerDown),
    .dlySelLong (dlySelLong),
    .extCtrlEn  (extCtrlEn),
    .holdClkCfg (holdClkCfg),
    .calBusy    (calBusy),
    .dclkEn     (dclkEn)
  );

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelClear();
    mLow = 0; mHigh = 0; mArmed = 0;
  endfunction

  function automatic void modelStep(logic req, logic pd);
    if (pd) begin
      mMode = 0;
      modelClear();
    end else if (mMode == 1) begin
      mRemain--;
      if (mRemain == 0) mMode = 0;
      modelClear();
    end else if (!req) begin
      mLow++;
      mHigh  = 0;
      mArmed = (mLow >= QUAL);
    end else begin
      mLow = 0;
      if (mArmed) begin
        mHigh++;
        if (mHigh == QUAL) begin
          mMode = 1; mRemain = CALN; mArmed = 0; mHigh = 0;
        end
      end
    end
  endfunction

  task automatic step(string tag, logic req, logic pd);
    calReq = req;
    powerDown = pd;
    @(negedge clk);
    modelStep(req, pd);
    check(tag, calBusy, logic'(mMode == 1));
    check({tag, " R11 clk"}, dclkEn, logic'(!(mMode == 1 && holdClkCfg)));
  endtask

  task automatic drive(string tag, logic req, int n);
    repeat (n) step(tag, req, 1'b0);
  endtask

  task automatic powerUp(string tag, bit sel, bit ext, int waitLen);
    rstN = 1'b0; calReq = 1'b0; powerDown = 1'b0;
    dlySelLong = sel; extCtrlEn = ext;
    repeat (3) @(negedge clk);
    check("R1 reset busy", calBusy, 1'b0);
    check("R1 reset dclkEn", dclkEn, 1'b1);
    rstN = 1'b1;
    repeat (waitLen - 1) @(negedge clk);
    check({tag, " early"}, calBusy, 1'b0);
    @(negedge clk);
    check(tag, calBusy, 1'b1);
    check("R11 clock held", dclkEn, 1'b0);
    repeat (CALN - 1) @(negedge clk);
    check("R5 still busy", calBusy, 1'b1);
    @(negedge clk);
    check("R5 busy falls", calBusy, 1'b0);
    mMode = 0;
    modelClear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5a7));
    holdClkCfg = 1'b1;
    rstN = 1'b0; calReq = 1'b0; powerDown = 1'b0;
    dlySelLong = 1'b0; extCtrlEn = 1'b0;
    @(negedge clk);

    powerUp("R2 short wait", 1'b0, 1'b0, 1 << SLOG);
    powerUp("R3 long wait", 1'b1, 1'b0, 1 << LLOG);
    powerUp("R4 ext forces short", 1'b1, 1'b1, 1 << SLOG);

    // R6 exact boundary: QUAL lows then QUAL highs
    drive("R6 low", 1'b0, QUAL);
    drive("R6 high", 1'b1, QUAL - 1);
    check("R6 not yet", calBusy, 1'b0);
    drive("R6 fire", 1'b1, 1);
    check("R6 busy rose", calBusy, 1'b1);
    // R9 request held high through calibration
    drive("R9 high during cal", 1'b1, CALN);
    check("R5 done after countdown", calBusy, 1'b0);
    drive("R9 no retrigger", 1'b1, 20);
    check("R9 idle", calBusy, 1'b0);

    // R7 short low phase
    drive("R7 low", 1'b0, QUAL - 1);
    drive("R7 high", 1'b1, QUAL + 20);
    check("R7 no cal", calBusy, 1'b0);

    // R8 interrupted high phase forces a full recount
    drive("R8 low", 1'b0, QUAL + 10);
    drive("R8 short high", 1'b1, QUAL - 1);
    drive("R8 short relow", 1'b0, QUAL - 1);
    drive("R8 high", 1'b1, QUAL + 10);
    check("R8 no cal", calBusy, 1'b0);
    drive("R8 low ok", 1'b0, QUAL);
    drive("R8 high ok", 1'b1, QUAL);
    check("R6 after recount", calBusy, 1'b1);

    // R9 low time during calibration does not count
    drive("R9 low in cal", 1'b0, CALN - 1 + 10);
    drive("R9 high", 1'b1, QUAL + 10);
    check("R9 low in cal ignored", calBusy, 1'b0);

    // R11 no hold
    holdClkCfg = 1'b0;
    drive("R11 low", 1'b0, QUAL);
    drive("R11 high", 1'b1, QUAL);
    check("R11 busy", calBusy, 1'b1);
    check("R11 free clock", dclkEn, 1'b1);
    drive("R11 run", 1'b1, CALN);
    holdClkCfg = 1'b1;

    // R10 power-down aborts
    drive("R10 low", 1'b0, QUAL);
    drive("R10 high", 1'b1, QUAL);
    drive("R10 running", 1'b1, 10);
    check("R10 running", calBusy, 1'b1);
    step("R10 abort", 1'b1, 1'b1);
    check("R10 aborted", calBusy, 1'b0);
    repeat (QUAL + 10) step("R10 pd low", 1'b0, 1'b1);
    repeat (30) step("R10 pd high", 1'b1, 1'b1);
    drive("R10 released", 1'b1, QUAL + 10);
    check("R10 stays idle", calBusy, 1'b0);

    // random phase lengths around the threshold
    for (int t = 0; t < 40; t++) begin
      int lowLen  = QUAL - 8 + int'($urandom % 17);
      int highLen = QUAL - 8 + int'($urandom % 17);
      int pdAt    = (($urandom % 6) == 0) ? int'($urandom % (lowLen + highLen)) : -1;
      int k = 0;
      holdClkCfg = logic'($urandom % 2);
      for (int i = 0; i < lowLen; i++) begin
        step("R6 rand low", 1'b0, logic'(k == pdAt)); k++;
      end
      for (int i = 0; i < highLen; i++) begin
        step("R7 rand high", 1'b1, logic'(k == pdAt)); k++;
      end
      drive("R9 rand tail", logic'($urandom % 2), CALN);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule